// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block sits beside the final stage of a simple in-order pipeline and performs the entry into an exception handler. Each cycle it receives a vector of fault requests, one bit per fault kind, together with the faulting PC, the faulting virtual address, the translation details (ASID and VPN), the load/store direction and the coprocessor number. When any request is present, it picks one winner by fixed priority and computes the 5-bit exception code and the handler vector. It then updates the architectural exception state on the next clock edge.

The handler vector is a base plus an offset. The base comes from a programmable exception base when the boot-mode bit is set, and from a fixed constant otherwise. The offset depends on the fault kind, the interrupt-vector mode bit and whether the unit was already inside a handler. Translation faults also record the faulting page number and address-space identifier, so the handler can refill the translation entry without decoding the instruction again. A redirect strobe with the new PC tells the fetch stage where to go.

Top module: `exc_entry_unit`

## Requirements
- R1: Request bit positions are machine check 0, address error 1, TLB refill 2, TLB invalid 3, TLB modified 4, coprocessor unusable 5, syscall 6, breakpoint 7, reserved instruction 8, overflow 9, trap 10 and interrupt 11. When several bits are set, the lowest set position wins.
- R2: The reported code is 24 for machine check, 11 for coprocessor unusable, 8 for syscall, 9 for breakpoint, 10 for reserved instruction, 12 for overflow, 13 for trap and 0 for interrupt.
- R3: Address error reports 5 on a store and 4 on a load. TLB refill and TLB invalid report 3 on a store and 2 on a load. TLB modified reports 1 whatever the direction.
- R4: The vector base is `ebaseVal` when `bevMode` is 1 and 0xBFC00200 when it is 0.
- R5: The vector offset is 0x200 for an interrupt with `ivMode` = 1 and 0x000 with `ivMode` = 0. It is 0x180 for a TLB refill taken while `statusExl` is 1 and 0x000 while it is 0. It is 0x180 for every other kind.
- R6: `redirectValid` is high in the cycle after each cycle that carries at least one request, and low after a cycle with none. `redirectPc` and `excCode` then show that entry's vector and code and hold until the next entry.
- R7: On entry `statusExl` becomes 1 and `epc` captures `faultPc`. A cycle with no request and `leaveHandler` high clears `statusExl`. A request in the same cycle wins over `leaveHandler`.
- R8: `badVaddr` takes `faultVaddr` only on an address error or any of the three TLB faults. Otherwise it keeps its value.
- R9: On any of the three TLB faults, `entryHiAsid` takes `faultAsid`, and `entryHiVpn2` and `contextBadVpn2` take `faultVpn` shifted right by 2. `entryHiVpn2x` takes `faultVpn[1:0]`. Other faults leave all four unchanged.
- R10: `causeCe` takes `copNum` only on a coprocessor unusable entry. Otherwise it keeps its value.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| faultReq | input | 12 | One request bit per fault kind |
| isStore | input | 1 | Faulting access was a store |
| faultPc | input | 32 | PC of the faulting instruction |
| faultVaddr | input | 32 | Faulting virtual address |
| faultAsid | input | 8 | Address-space identifier of the faulting access |
| faultVpn | input | 21 | Faulting virtual page number |
| copNum | input | 2 | Coprocessor number for an unusable fault |
| bevMode | input | 1 | Selects the programmable vector base |
| ebaseVal | input | 32 | Programmable exception base |
| ivMode | input | 1 | Selects the dedicated interrupt offset |
| leaveHandler | input | 1 | Handler return: clears the in-handler flag |
| redirectValid | output | 1 | One-cycle strobe per accepted exception |
| redirectPc | output | 32 | Handler vector |
| excCode | output | 5 | Reported exception code |
| causeCe | output | 2 | Recorded coprocessor number |
| epc | output | 32 | Captured faulting PC |
| statusExl | output | 1 | In-handler flag |
| badVaddr | output | 32 | Recorded faulting address |
| entryHiAsid | output | 8 | Recorded ASID |
| entryHiVpn2 | output | 19 | Recorded VPN shifted right by 2 |
| entryHiVpn2x | output | 2 | Recorded low two VPN bits |
| contextBadVpn2 | output | 19 | Recorded VPN shifted right by 2, context copy |

## Verification
The bench drives a TLB refill twice in a row without a handler return. A design that read the in-handler flag after updating it, rather than before, would get the 0x000 versus 0x180 choice wrong on one of the two. It also raises every request bit at once and random pairs of bits, to catch a priority encoder that lets the highest position win. It sends stores through TLB modified, where a design that shared the load/store code selection with the other TLB faults would report 3 instead of 1. Random runs mix faults that must not touch BadVAddr, the translation fields or the coprocessor field, so a design with a loosely gated write enable would corrupt held values.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int NUM_KINDS = 12;
  localparam int KIDX_W    = $clog2(NUM_KINDS);
  localparam int CODE_W    = 5;

  // Request bit positions; lower position means higher priority.
  localparam logic [KIDX_W-1:0] K_MCHECK = 4'd0;
  localparam logic [KIDX_W-1:0] K_ADDRERR = 4'd1;
  localparam logic [KIDX_W-1:0] K_TLBREFILL = 4'd2;
  localparam logic [KIDX_W-1:0] K_TLBINVAL = 4'd3;
  localparam logic [KIDX_W-1:0] K_TLBMOD = 4'd4;
  localparam logic [KIDX_W-1:0] K_COPUNUSE = 4'd5;
  localparam logic [KIDX_W-1:0] K_SYSCALL = 4'd6;
  localparam logic [KIDX_W-1:0] K_BREAK = 4'd7;
  localparam logic [KIDX_W-1:0] K_RESINSTR = 4'd8;
  localparam logic [KIDX_W-1:0] K_OVERFLOW = 4'd9;
  localparam logic [KIDX_W-1:0] K_TRAP = 4'd10;
  localparam logic [KIDX_W-1:0] K_INTR = 4'd11;

  typedef enum logic [1:0] {
    OFF_GENERAL = 2'd0,
    OFF_INTR    = 2'd1,
    OFF_REFILL  = 2'd2
  } offSel_e;

  typedef struct packed {
    logic              take;
    logic              ldBadVaddr;
    logic              ldTlb;
    logic              ldCe;
    offSel_e           offSel;
    logic [CODE_W-1:0] code;
  } entryStrobes_t;

endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_KINDS-1:0] faultReq,
  input  logic                 isStore,
  output entryStrobes_t        strobes
);

  logic [KIDX_W-1:0]    winIdx;
  logic [NUM_KINDS-1:0] grant;

  // Lowest set bit, isolated arithmetically (used to cross-check the scan).
  assign grant = faultReq & ~(faultReq - NUM_KINDS'(1));

  always_comb begin
    winIdx = '0;
    for (int i = NUM_KINDS - 1; i >= 0; i--) begin
      if (faultReq[i]) winIdx = KIDX_W'(i);
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.offSel     = OFF_GENERAL;
    if (|faultReq) begin
      strobes.take = 1'b1;
      unique case (winIdx)
        K_MCHECK:    strobes.code = 5'd24;
        K_ADDRERR: begin
          strobes.code       = isStore ? 5'd5 : 5'd4;
          strobes.ldBadVaddr = 1'b1;
        end
        K_TLBREFILL: begin
          strobes.code       = isStore ? 5'd3 : 5'd2;
          strobes.ldBadVaddr = 1'b1;
          strobes.ldTlb      = 1'b1;
          strobes.offSel     = OFF_REFILL;
        end
        K_TLBINVAL: begin
          strobes.code       = isStore ? 5'd3 : 5'd2;
          strobes.ldBadVaddr = 1'b1;
          strobes.ldTlb      = 1'b1;
        end
        K_TLBMOD: begin
          strobes.code       = 5'd1;
          strobes.ldBadVaddr = 1'b1;
          strobes.ldTlb      = 1'b1;
        end
        K_COPUNUSE: begin
          strobes.code = 5'd11;
          strobes.ldCe = 1'b1;
        end
        K_SYSCALL:   strobes.code = 5'd8;
        K_BREAK:     strobes.code = 5'd9;
        K_RESINSTR:  strobes.code = 5'd10;
        K_OVERFLOW:  strobes.code = 5'd12;
        K_TRAP:      strobes.code = 5'd13;
        K_INTR: begin
          strobes.code   = 5'd0;
          strobes.offSel = OFF_INTR;
        end
        default:     strobes.code = 5'd0;
      endcase
    end
  end

  // R1: exactly one winner, and the scan agrees with the isolated lowest bit
  a_r1_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (|faultReq) |-> ($onehot0(grant) && grant[winIdx]));

  // R8: address writes only come with a translation or address fault
  a_r8_tlb_implies_badv: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.ldTlb |-> strobes.ldBadVaddr);

endmodule

// File: rtl/exc_entry_dpath.sv
module exc_entry_dpath
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ASID_W = 8,
  parameter int VPN_W  = 21,
  parameter int CE_W   = 2,
  parameter logic [ADDR_W-1:0] FIXED_BASE = 32'hBFC0_0200,
  localparam int VPN2_W = VPN_W - 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  entryStrobes_t        strobes,
  input  logic [ADDR_W-1:0]    faultPc,
  input  logic [ADDR_W-1:0]    faultVaddr,
  input  logic [ASID_W-1:0]    faultAsid,
  input  logic [VPN_W-1:0]     faultVpn,
  input  logic [CE_W-1:0]      copNum,
  input  logic                 bevMode,
  input  logic [ADDR_W-1:0]    ebaseVal,
  input  logic                 ivMode,
  input  logic                 leaveHandler,
  output logic                 redirectValid,
  output logic [ADDR_W-1:0]    redirectPc,
  output logic [CODE_W-1:0]    excCode,
  output logic [CE_W-1:0]      causeCe,
  output logic [ADDR_W-1:0]    epc,
  output logic                 statusExl,
  output logic [ADDR_W-1:0]    badVaddr,
  output logic [ASID_W-1:0]    entryHiAsid,
  output logic [VPN2_W-1:0]    entryHiVpn2,
  output logic [1:0]           entryHiVpn2x,
  output logic [VPN2_W-1:0]    contextBadVpn2
);

  logic [ADDR_W-1:0] vecBase;
  logic [ADDR_W-1:0] vecOffset;
  logic [ADDR_W-1:0] vecNext;

  always_comb begin
    vecBase = bevMode ? ebaseVal : FIXED_BASE;
    unique case (strobes.offSel)
      OFF_INTR:   vecOffset = ivMode ? ADDR_W'(12'h200) : '0;
      OFF_REFILL: vecOffset = statusExl ? ADDR_W'(12'h180) : '0;
      default:    vecOffset = ADDR_W'(12'h180);
    endcase
    vecNext = vecBase + vecOffset;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirectValid  <= 1'b0;
      redirectPc     <= '0;
      excCode        <= '0;
      causeCe        <= '0;
      epc            <= '0;
      statusExl      <= 1'b0;
      badVaddr       <= '0;
      entryHiAsid    <= '0;
      entryHiVpn2    <= '0;
      entryHiVpn2x   <= '0;
      contextBadVpn2 <= '0;
    end else begin
      redirectValid <= strobes.take;
      if (strobes.take) begin
        redirectPc <= vecNext;
        excCode    <= strobes.code;
        epc        <= faultPc;
        statusExl  <= 1'b1;
      end else if (leaveHandler) begin
        statusExl  <= 1'b0;
      end
      if (strobes.ldBadVaddr) badVaddr <= faultVaddr;
      if (strobes.ldTlb) begin
        entryHiAsid    <= faultAsid;
        entryHiVpn2    <= faultVpn[VPN_W-1:2];
        entryHiVpn2x   <= faultVpn[1:0];
        contextBadVpn2 <= faultVpn[VPN_W-1:2];
      end
      if (strobes.ldCe) causeCe <= copNum;
    end
  end

  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.take |=> redirectValid);

  a_r6_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.take |=> !redirectValid);

  a_r7_exl_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.take |=> (statusExl && epc == $past(faultPc)));

  a_r8_badv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.ldBadVaddr |=> $stable(badVaddr));

  a_r9_tlb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.ldTlb |=> ($stable(entryHiAsid) && $stable(contextBadVpn2)));

  a_r10_ce_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.ldCe |=> $stable(causeCe));

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ASID_W = 8,
  parameter int VPN_W  = 21,
  parameter int CE_W   = 2,
  localparam int VPN2_W = VPN_W - 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_KINDS-1:0] faultReq,
  input  logic                 isStore,
  input  logic [ADDR_W-1:0]    faultPc,
  input  logic [ADDR_W-1:0]    faultVaddr,
  input  logic [ASID_W-1:0]    faultAsid,
  input  logic [VPN_W-1:0]     faultVpn,
  input  logic [CE_W-1:0]      copNum,
  input  logic                 bevMode,
  input  logic [ADDR_W-1:0]    ebaseVal,
  input  logic                 ivMode,
  input  logic                 leaveHandler,
  output logic                 redirectValid,
  output logic [ADDR_W-1:0]    redirectPc,
  output logic [CODE_W-1:0]    excCode,
  output logic [CE_W-1:0]      causeCe,
  output logic [ADDR_W-1:0]    epc,
  output logic                 statusExl,
  output logic [ADDR_W-1:0]    badVaddr,
  output logic [ASID_W-1:0]    entryHiAsid,
  output logic [VPN2_W-1:0]    entryHiVpn2,
  output logic [1:0]           entryHiVpn2x,
  output logic [VPN2_W-1:0]    contextBadVpn2
);

  entryStrobes_t strobes;

  exc_entry_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .faultReq (faultReq),
    .isStore  (isStore),
    .strobes  (strobes)
  );

  exc_entry_dpath #(
    .ADDR_W (ADDR_W),
    .ASID_W (ASID_W),
    .VPN_W  (VPN_W),
    .CE_W   (CE_W)
  ) u_dpath (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobes        (strobes),
    .faultPc        (faultPc),
    .faultVaddr     (faultVaddr),
    .faultAsid      (faultAsid),
    .faultVpn       (faultVpn),
    .copNum         (copNum),
    .bevMode        (bevMode),
    .ebaseVal       (ebaseVal),
    .ivMode         (ivMode),
    .leaveHandler   (leaveHandler),
    .redirectValid  (redirectValid),
    .redirectPc     (redirectPc),
    .excCode        (excCode),
    .causeCe        (causeCe),
    .epc            (epc),
    .statusExl      (statusExl),
    .badVaddr       (badVaddr),
    .entryHiAsid    (entryHiAsid),
    .entryHiVpn2    (entryHiVpn2),
    .entryHiVpn2x   (entryHiVpn2x),
    .contextBadVpn2 (contextBadVpn2)
  );

endmodule

// File: tb/tb_exc_entry_unit.sv
`timescale 1ns/1ps
module tb_exc_entry_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] faultReq;
  logic        isStore;
  logic [31:0] faultPc, faultVaddr, ebaseVal;
  logic [7:0]  faultAsid;
  logic [20:0] faultVpn;
  logic [1:0]  copNum;
  logic        bevMode, ivMode, leaveHandler;
  logic        redirectValid;
  logic [31:0] redirectPc, epc, badVaddr;
  logic [4:0]  excCode;
  logic [1:0]  causeCe, entryHiVpn2x;
  logic        statusExl;
  logic [7:0]  entryHiAsid;
  logic [18:0] entryHiVpn2, contextBadVpn2;

  always #2 clk = ~clk;

  exc_entry_unit dut (.*);

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // Bench model state
  logic        mValid, mExl;
  logic [31:0] mPc, mEpc, mBadV;
  logic [4:0]  mCode;
  logic [1:0]  mCe, mVpn2x;
  logic [7:0]  mAsid;
  logic [18:0] mVpn2, mCtx;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int winner(logic [11:0] req);
    for (int i = 0; i < 12; i++) if (req[i]) return i;
    return -1;
  endfunction

  function automatic logic [4:0] expCode(int k, logic st);
    case (k)
      0: return 5'd24;
      1: return st ? 5'd5 : 5'd4;
      2, 3: return st ? 5'd3 : 5'd2;
      4: return 5'd1;
      5: return 5'd11;
      6: return 5'd8;
      7: return 5'd9;
      8: return 5'd10;
      9: return 5'd12;
      10: return 5'd13;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [31:0] expVec(int k, logic bev, logic [31:0] eb,
                                         logic iv, logic exl);
    logic [31:0] b, o;
    b = bev ? eb : 32'hBFC0_0200;
    if (k == 11) o = iv ? 32'h200 : 32'h0;
    else if (k == 2) o = exl ? 32'h180 : 32'h0;
    else o = 32'h180;
    return b + o;
  endfunction

  task automatic resetModel();
    mValid = 0; mExl = 0; mPc = 0; mEpc = 0; mBadV = 0; mCode = 0;
    mCe = 0; mVpn2x = 0; mAsid = 0; mVpn2 = 0; mCtx = 0;
  endtask

  task automatic checkAll(string ctx);
    check({ctx, " R6 valid"}, 32'(redirectValid), 32'(mValid));
    check({ctx, " R4/R5 vector"}, redirectPc, mPc);
    check({ctx, " R2/R3 code"}, 32'(excCode), 32'(mCode));
    check({ctx, " R7 exl"}, 32'(statusExl), 32'(mExl));
    check({ctx, " R7 epc"}, epc, mEpc);
    check({ctx, " R8 badvaddr"}, badVaddr, mBadV);
    check({ctx, " R9 asid"}, 32'(entryHiAsid), 32'(mAsid));
    check({ctx, " R9 vpn2"}, 32'(entryHiVpn2), 32'(mVpn2));
    check({ctx, " R9 vpn2x"}, 32'(entryHiVpn2x), 32'(mVpn2x));
    check({ctx, " R9 context"}, 32'(contextBadVpn2), 32'(mCtx));
    check({ctx, " R10 ce"}, 32'(causeCe), 32'(mCe));
  endtask

  // Drive at negedge, update model at posedge, sample 1 ns later.
  task automatic step(logic [11:0] req, logic st, logic bev, logic iv,
                      logic lh, string ctx);
    int k;
    @(negedge clk);
    faultReq = req; isStore = st; bevMode = bev; ivMode = iv;
    leaveHandler = lh;
    faultPc = $urandom; faultVaddr = $urandom; ebaseVal = $urandom & 32'hFFFF_F000;
    faultAsid = 8'($urandom); faultVpn = 21'($urandom); copNum = 2'($urandom);
    @(posedge clk);
    k = winner(req);
    mValid = (k >= 0);
    if (k >= 0) begin
      mPc = expVec(k, bev, ebaseVal, iv, mExl);
      mCode = expCode(k, st);
      mEpc = faultPc;
      if (k >= 1 && k <= 4) mBadV = faultVaddr;
      if (k >= 2 && k <= 4) begin
        mAsid = faultAsid; mVpn2 = faultVpn[20:2];
        mVpn2x = faultVpn[1:0]; mCtx = faultVpn[20:2];
      end
      if (k == 5) mCe = copNum;
      mExl = 1'b1;
    end else if (lh) begin
      mExl = 1'b0;
    end
    #1;
    checkAll(ctx);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; faultReq = 0; isStore = 0; faultPc = 0; faultVaddr = 0;
    ebaseVal = 0; faultAsid = 0; faultVpn = 0; copNum = 0; bevMode = 0;
    ivMode = 0; leaveHandler = 0;
    resetModel();
    repeat (3) @(posedge clk);
    #1;
    checkAll("R11 reset");
    @(negedge clk); rst_n = 1;

    // R1/R2/R3: each kind alone, load then store, leaving handler between
    for (int k = 0; k < 12; k++) begin
      step(12'(1) << k, 1'b0, 1'b0, 1'b0, 1'b0, "R2 single load");
      step(12'h0, 1'b0, 1'b0, 1'b0, 1'b1, "R7 leave");
      step(12'(1) << k, 1'b1, 1'b1, 1'b1, 1'b0, "R3 single store");
      step(12'h0, 1'b0, 1'b0, 1'b0, 1'b1, "R7 leave");
    end
    // R5: refill while in handler vs outside
    step(12'h004, 1'b0, 1'b0, 1'b0, 1'b0, "R5 refill exl0");
    step(12'h004, 1'b1, 1'b0, 1'b0, 1'b1, "R5 refill exl1 R7 req beats leave");
    step(12'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 hold exl");
    // R5: interrupt with both iv settings, R4 both bases
    step(12'h800, 1'b0, 1'b1, 1'b0, 1'b0, "R5 intr iv0");
    step(12'h800, 1'b0, 1'b0, 1'b1, 1'b0, "R5 intr iv1");
    // R3: TLB modified on store still code 1
    step(12'h010, 1'b1, 1'b0, 1'b0, 1'b0, "R3 tlbmod store");
    // R1: all requests at once, then pairs
    step(12'hFFF, 1'b1, 1'b0, 1'b0, 1'b0, "R1 all");
    step(12'h820, 1'b0, 1'b0, 1'b0, 1'b0, "R1 cop over intr");
    step(12'h018, 1'b1, 1'b0, 1'b0, 1'b0, "R1 invalid over mod");
    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [11:0] r;
      case ($urandom % 4)
        0: r = 12'h0;
        1: r = 12'(1) << ($urandom % 12);
        default: r = 12'($urandom);
      endcase
      step(r, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R1 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule